// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block gathers a vector of interrupt lines and turns them into two processor requests: a normal request and a fast request. Each request comes from its own bank of configuration registers, and both banks watch the same synchronized input lines. Software sets up each line separately in each bank. It picks level or edge sensitivity, picks the active sense, and enables or disables the line. It acknowledges captured edges by writing ones.

Every input first passes through a two-flop synchronizer. An edge detector then looks at the synchronized lines. In edge mode, an edge of the chosen direction sets a sticky capture bit. In level mode, the line's state, adjusted for polarity, is used directly. The bank shows this pre-mask word as its source word. It ANDs the source word with the enable word to form the status word, and drives its request output high while any status bit is set. Access is through a plain synchronous register port: a write strobe with address and data, and a read data word that follows the address combinationally.

Top module: `dual_bank_intc`

## Requirements
- R1: There is one bit per line in every register. Each bank has six registers at byte offsets: source 0x00 (read-only), enable 0x04, acknowledge 0x08 (write-only, reads 0), trigger mode 0x0C, polarity 0x10, status 0x14 (read-only). Address bit 5 selects the bank: 0 for the normal bank, 1 for the fast bank at 0x20 to 0x34. Writes to the read-only registers change nothing.
- R2: After reset every register reads 0, so every line is disabled and set to level, active-high. Both request outputs are low.
- R3: The enable register reads back the last value written. A 1 bit enables that line.
- R4: With mode bit 0 (level), the source bit equals the input XOR the polarity bit: polarity 1 means active-low. It follows the input no more than 3 clock cycles after the input changes.
- R5: With mode bit 1 (edge), a rising edge (polarity 0) or a falling edge (polarity 1) sets a sticky source bit within 3 cycles. The bit stays set after the input returns. An edge in the other direction does not set it.
- R6: Writing the acknowledge register clears the captured edge bits where the data has a 1. Bits where the data has a 0 are left alone, and acknowledging a level-mode line has no effect.
- R7: When an edge is detected in the same cycle that its bit is acknowledged, the new edge wins and the bit stays set.
- R8: Status equals source AND enable. Each request output is the OR of its bank's status bits.
- R9: The two banks are independent: configuration written to one bank changes neither the other bank's registers nor its request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| line_in | input | 32 | Asynchronous interrupt lines |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
The bench drives a falling edge on a line in exactly the cycle that an acknowledge of that line is captured. A design that let the acknowledge win would lose that interrupt. It also sets opposite polarities on the two halves of the word and then toggles every line. A design that swapped the polarity sense would capture the wrong half, or would turn a level line active-low into active-high. It writes acknowledges to level lines and to read-only registers, which a design that decoded them wrongly would corrupt. Finally, it sweeps a single enabled line across all 32 positions to catch any bit-slice wiring or masking error, and it checks that one bank's configuration never reaches the other bank's request.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
   // Word index within a bank (bus_addr[4:2]); software decodes these.
   typedef enum logic [2:0] {
      RSEL_SRC  = 3'd0,
      RSEL_EN   = 3'd1,
      RSEL_ACK  = 3'd2,
      RSEL_MODE = 3'd3,
      RSEL_POL  = 3'd4,
      RSEL_STAT = 3'd5
   } reg_sel_e;

   localparam int BANK_SPAN_BYTES = 32;
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dbi_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= '0;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbi_edge.sv
module dbi_edge #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/dbi_bank.sv
module dbi_bank #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] rise,
   input  logic [N-1:0] fall,
   input  logic         wr_en,
   input  logic         wr_ack,
   input  logic         wr_mode,
   input  logic         wr_pol,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] src,
   output logic [N-1:0] en,
   output logic [N-1:0] mode,
   output logic [N-1:0] pol,
   output logic [N-1:0] stat,
   output logic         req
);
   logic [N-1:0] en_q, mode_q, pol_q, latch_q;
   logic [N-1:0] ack_vec, edge_hit, latch_d;

   assign ack_vec  = wr_ack ? wdata : '0;
   assign edge_hit = mode_q & ((rise & ~pol_q) | (fall & pol_q));
   assign latch_d  = (latch_q & ~ack_vec & mode_q) | edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         mode_q  <= '0;
         pol_q   <= '0;
         latch_q <= '0;
      end else begin
         if (wr_en)   en_q   <= wdata;
         if (wr_mode) mode_q <= wdata;
         if (wr_pol)  pol_q  <= wdata;
         latch_q <= latch_d;
      end
   end

   assign src  = (mode_q & latch_q) | (~mode_q & (lvl ^ pol_q));
   assign stat = src & en_q;
   assign req  = |stat;
   assign en   = en_q;
   assign mode = mode_q;
   assign pol  = pol_q;

   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R3: enable register takes the written word
   a_r3_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> en_q == $past(wdata));

   // R5: a captured edge stays unless acknowledged or mode is dropped
   a_r5_sticky_edge: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (($past(latch_q) & $past(mode_q) & ~$past(ack_vec) & mode_q & ~latch_q) == '0));

   // R7: a detected edge is always captured, even under acknowledge
   a_r7_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> ((latch_q & $past(edge_hit)) == $past(edge_hit)));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
   parameter int NLINES      = 32,
   parameter int DW          = 32,
   parameter int AW          = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NLINES-1:0] line_in,
   output logic              irq_o,
   output logic              fiq_o
);
   import dbi_pkg::*;

   localparam int NBANKS   = 2;
   localparam int BANK_BIT = $clog2(BANK_SPAN_BYTES);

   if (NLINES < 1 || NLINES > DW) begin : g_bad_lines
      $error("dual_bank_intc: NLINES must be in 1..DW");
   end
   if (AW != BANK_BIT + 1) begin : g_bad_aw
      $error("dual_bank_intc: AW must cover exactly two banks");
   end

   logic [NLINES-1:0] lvl, rise, fall;

   dbi_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(lvl));

   dbi_edge #(.W(NLINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall));

   reg_sel_e          rsel;
   logic              bsel;
   logic [NLINES-1:0] wd;
   logic [NLINES-1:0] b_src  [NBANKS];
   logic [NLINES-1:0] b_en   [NBANKS];
   logic [NLINES-1:0] b_mode [NBANKS];
   logic [NLINES-1:0] b_pol  [NBANKS];
   logic [NLINES-1:0] b_stat [NBANKS];
   logic [NBANKS-1:0] b_req;

   assign rsel = reg_sel_e'(bus_addr[BANK_BIT-1:2]);
   assign bsel = bus_addr[BANK_BIT];
   assign wd   = bus_wdata[NLINES-1:0];

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic hit;
      assign hit = bus_wr && (bsel == b[0]);

      dbi_bank #(.N(NLINES)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl    (lvl),
         .rise   (rise),
         .fall   (fall),
         .wr_en  (hit && rsel == RSEL_EN),
         .wr_ack (hit && rsel == RSEL_ACK),
         .wr_mode(hit && rsel == RSEL_MODE),
         .wr_pol (hit && rsel == RSEL_POL),
         .wdata  (wd),
         .src    (b_src[b]),
         .en     (b_en[b]),
         .mode   (b_mode[b]),
         .pol    (b_pol[b]),
         .stat   (b_stat[b]),
         .req    (b_req[b]));
   end

   logic [NLINES-1:0] rd_word;
   always_comb begin
      unique case (rsel)
         RSEL_SRC:  rd_word = b_src[bsel];
         RSEL_EN:   rd_word = b_en[bsel];
         RSEL_MODE: rd_word = b_mode[bsel];
         RSEL_POL:  rd_word = b_pol[bsel];
         RSEL_STAT: rd_word = b_stat[bsel];
         default:   rd_word = '0;
      endcase
   end

   if (NLINES < DW) begin : g_pad
      assign bus_rdata = {{(DW-NLINES){1'b0}}, rd_word};
   end else begin : g_nopad
      assign bus_rdata = rd_word;
   end

   assign irq_o = b_req[0];
   assign fiq_o = b_req[1];

   // R8: no request from a bank whose enable word is zero
   a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en[0] == '0) |-> !irq_o);
   // R9: fast bank request independent of normal bank enables
   a_r9_fast_needs_own_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en[1] == '0) |-> !fiq_o);
endmodule

// File: tb/test_dual_bank_intc.sv
module test_dual_bank_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] line_in = '0;
   logic        irq_o, fiq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dual_bank_intc i_dual_bank_intc (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
      .irq_o(irq_o), .fiq_o(fiq_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < 6; r++)
            rd("R2", 6'(b*32 + r*4), 32'h0);
      chk("R2 irq", {31'b0, irq_o}, 0);
      chk("R2 fiq", {31'b0, fiq_o}, 0);

      // R3 enable read/write; R1 layout and read-only registers
      wr(6'h04, 32'hA5A5_0F0F);
      wr(6'h24, 32'h1234_5678);
      rd("R3", 6'h04, 32'hA5A5_0F0F);
      rd("R3", 6'h24, 32'h1234_5678);
      wr(6'h00, 32'hFFFF_FFFF);
      wr(6'h14, 32'hFFFF_FFFF);
      wr(6'h28, 32'hFFFF_FFFF);
      rd("R1 src ro", 6'h00, 32'h0);
      rd("R1 stat ro", 6'h14, 32'h0);
      rd("R1 ack reads 0", 6'h28, 32'h0);
      rd("R1 mode", 6'h0C, 32'h0);
      wr(6'h0C, 32'h0000_00F0);
      rd("R1 mode", 6'h0C, 32'h0000_00F0);
      wr(6'h0C, 32'h0);

      // R4/R8 level mode, mixed polarity in normal bank
      wr(6'h04, 32'hFFFF_FFFF);
      wr(6'h10, 32'hF0F0_F0F0);
      rd("R4 pol", 6'h10, 32'hF0F0_F0F0);
      begin
         logic [31:0] pats [4];
         pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF;
         pats[2] = 32'hF0F0_F0F0; pats[3] = 32'h1357_9BDF;
         for (int p = 0; p < 4; p++) begin
            line_in = pats[p];
            idle(3);
            rd("R4 src", 6'h00, pats[p] ^ 32'hF0F0_F0F0);
            rd("R8 stat", 6'h14, pats[p] ^ 32'hF0F0_F0F0);
            chk("R8 irq", {31'b0, irq_o}, {31'b0, |(pats[p] ^ 32'hF0F0_F0F0)});
         end
      end
      // R8 partial enable
      line_in = 32'h0000_00FF;
      wr(6'h04, 32'h0000_0F00);
      idle(3);
      rd("R8 stat masked", 6'h14, 32'h0000_0F00 & (32'h0000_00FF ^ 32'hF0F0_F0F0));
      rd("R9 fast untouched", 6'h30, 32'h0);

      // R5/R6 edge mode in fast bank: upper half rising, lower half falling
      line_in = 32'h0;
      wr(6'h2C, 32'hFFFF_FFFF);
      wr(6'h30, 32'h0000_FFFF);
      wr(6'h24, 32'hFFFF_FFFF);
      idle(3);
      wr(6'h28, 32'hFFFF_FFFF);
      rd("R5 no edge", 6'h20, 32'h0);
      line_in = 32'hFFFF_FFFF;
      idle(3);
      rd("R5 rising only", 6'h20, 32'hFFFF_0000);
      chk("R8 fiq", {31'b0, fiq_o}, 1);
      line_in = 32'h0;
      idle(3);
      rd("R5 sticky+falling", 6'h20, 32'hFFFF_FFFF);
      wr(6'h28, 32'h0000_FF00);
      rd("R6 ack ones only", 6'h20, 32'hFFFF_00FF);
      rd("R6 stat", 6'h34, 32'hFFFF_00FF);
      wr(6'h28, 32'hFFFF_00FE);
      rd("R6 ack rest", 6'h20, 32'h0000_0001);

      // R7 edge coincident with acknowledge of that bit
      line_in = 32'h0000_0001;
      idle(3);
      rd("R7 setup", 6'h20, 32'h0000_0001);
      line_in = 32'h0;            // falling edge on bit 0
      idle(2);                    // edge detected during next cycle
      wr(6'h28, 32'h0000_0001);   // ack captured on same edge
      rd("R7 edge wins", 6'h20, 32'h0000_0001);
      idle(2);
      wr(6'h28, 32'h0000_0001);
      rd("R7 ack later", 6'h20, 32'h0);

      // R6 ack on level line ignored (normal bank, level)
      wr(6'h04, 32'hFFFF_FFFF);
      line_in = 32'h0000_0003;
      idle(3);
      wr(6'h08, 32'hFFFF_FFFF);
      rd("R6 level ack ignored", 6'h00, 32'h0000_0003 ^ 32'hF0F0_F0F0);

      // R9 independence of request outputs
      line_in = 32'hFFFF_FFFF;
      idle(3);
      wr(6'h04, 32'h0);
      chk("R9 irq off", {31'b0, irq_o}, 0);
      chk("R9 fiq on", {31'b0, fiq_o}, 1);
      wr(6'h28, 32'hFFFF_FFFF);
      chk("R9 fiq cleared", {31'b0, fiq_o}, 0);
      rd("R9 normal pol kept", 6'h10, 32'hF0F0_F0F0);

      // R8/R4 sweep each line alone, level active-high
      wr(6'h10, 32'h0);
      for (int i = 0; i < 32; i++) begin
         wr(6'h04, 32'h1 << i);
         line_in = 32'h1 << i;
         idle(3);
         rd("R8 sweep stat", 6'h14, 32'h1 << i);
         chk("R8 sweep irq", {31'b0, irq_o}, 1);
      end
      line_in = 32'h0;
      idle(3);
      chk("R4 released", {31'b0, irq_o}, 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule